// File: doc/BRIEF.md
# I2C Master Byte Engine

This block moves a single byte across an I2C bus on behalf of a master controller, once the bus is already owned. A host issues one of two commands. A transmit command latches a byte, clocks it out most significant bit first, and then gives the bus to the slave for a ninth clock to read its acknowledge. A receive command clocks eight bits in from the slave. An internal reload counter sets how long each SCL phase lasts.

Both bus lines are open-drain. The block only asserts an output-enable that pulls a line low, and it reads SDA back through a separate input. When a byte is finished, the block raises a one-cycle completion pulse and stops its clock generator. SCL stays pulled low until the host gives the next command.

Bus conditions (start, stop, repeated start), sending an acknowledge as a receiver, clock stretching and arbitration are handled by other logic.

Top module: `i2c_byte_engine`

## Requirements
- R1: Each SCL low phase and each SCL high phase of a transfer lasts (reload+1) clock cycles. The reload value is taken from `reload_i` on the edge that accepts the command, and it must be 1 or more.
- R2: In transmit, the 8 bits leave MSB first. A 0 bit is sent as `sda_oe_o`=1 and a 1 bit as `sda_oe_o`=0. SDA changes only while SCL is low.
- R3: For the whole ninth SCL high phase of a transmit, the master keeps SDA released (`sda_oe_o`=0).
- R4: `ack_stat_o` takes the SDA level sampled on the last cycle of the ninth high phase: 0 means acknowledged, 1 means not acknowledged. It holds that value until the ninth clock of the next transmit, and a receive does not change it.
- R5: `done_o` is high for exactly one cycle. It rises 18×(reload+1) cycles after the accepting edge for a transmit and 16×(reload+1) cycles after it for a receive, and `busy_o` falls at the same time. From then on SCL is parked low (`scl_oe_o`=1) until a new command is accepted.
- R6: In receive, SDA is sampled on the last cycle of each high phase, MSB first. The byte appears on `rx_byte_o` together with `done_o`. `sda_oe_o` stays 0 for the whole receive.
- R7: While `busy_o` is 1, `load_i` and `rx_start_i` have no effect: the byte in flight, its timing and its mode are unchanged.
- R8: If `load_i` and `rx_start_i` are both high in the same idle cycle, the transmit is accepted and the receive request is dropped.
- R9: Out of reset, `scl_oe_o`, `sda_oe_o`, `done_o`, `busy_o` and `ack_stat_o` are 0 and `rx_byte_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_i | input | 8 | SCL phase reload value, latched when a command is accepted |
| tx_byte_i | input | 8 | Byte to transmit, latched with `load_i` |
| load_i | input | 1 | Transmit command strobe |
| rx_start_i | input | 1 | Receive command strobe |
| rx_byte_o | output | 8 | Last byte received |
| ack_stat_o | output | 1 | Acknowledge status of the last transmitted byte (1 = not acknowledged) |
| done_o | output | 1 | One-cycle pulse when a byte completes |
| busy_o | output | 1 | A byte is in progress |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | SDA line level |

## Verification
The two commands can arrive together in one idle cycle. A command can also arrive in the middle of a byte that is already moving. To provoke the first case, the bench raises both strobes on the same edge. It then judges the result by the byte the slave model captures, by the exact completion latency of a transmit, and by `rx_byte_o` keeping its old value. To provoke the second case, the bench pulses both strobes with a different byte part-way through a transmit and part-way through a receive. It then checks that the captured data, the latency and the acknowledge status match the original command alone.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    typedef enum logic {
        MODE_TX = 1'b0,
        MODE_RX = 1'b1
    } xfer_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                run_i,
    input  logic [RELOAD_W-1:0] reload_i,
    output logic                tick_o
);

    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
        logic [RELOAD_W-1:0] rel;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (start_i) begin
            tmr_d.cnt = reload_i;
            tmr_d.rel = reload_i;
        end else if (run_i) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.cnt = tmr_q.rel;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick_o = run_i && (tmr_q.cnt == '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (tmr_q.cnt <= tmr_q.rel)); // R1

endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
    import i2c_eng_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             rx_start_i,
    input  logic             tick_i,
    output logic             start_o,
    output logic             take_tx_o,
    output logic             busy_o,
    output logic             mode_rx_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             sample_o,
    output logic             finish_o,
    output logic             done_o,
    output logic             scl_oe_o
);

    localparam logic [IDX_W-1:0] LAST_TX = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0] LAST_RX = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic             busy;
        xfer_mode_e       mode;
        scl_phase_e       phase;
        logic [IDX_W-1:0] idx;
        logic             done;
        logic             parked;
    } seq_t;

    seq_t seq_q, seq_d;

    logic             take_tx;
    logic             take_rx;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        last_idx = (seq_q.mode == MODE_RX) ? LAST_RX : LAST_TX;
        take_tx  = !seq_q.busy && load_i;
        take_rx  = !seq_q.busy && rx_start_i && !load_i;

        seq_d      = seq_q;
        seq_d.done = 1'b0;

        if (take_tx || take_rx) begin
            seq_d.busy  = 1'b1;
            seq_d.mode  = take_rx ? MODE_RX : MODE_TX;
            seq_d.phase = PH_LOW;
            seq_d.idx   = '0;
        end else if (seq_q.busy && tick_i) begin
            if (seq_q.phase == PH_LOW) begin
                seq_d.phase = PH_HIGH;
            end else begin
                seq_d.phase = PH_LOW;
                if (seq_q.idx == last_idx) begin
                    seq_d.busy   = 1'b0;
                    seq_d.done   = 1'b1;
                    seq_d.parked = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign start_o   = take_tx || take_rx;
    assign take_tx_o = take_tx;
    assign busy_o    = seq_q.busy;
    assign mode_rx_o = (seq_q.mode == MODE_RX);
    assign idx_o     = seq_q.idx;
    assign sample_o  = seq_q.busy && tick_i && (seq_q.phase == PH_HIGH);
    assign finish_o  = sample_o && (seq_q.idx == last_idx);
    assign done_o    = seq_q.done;
    assign scl_oe_o  = seq_q.busy ? (seq_q.phase == PH_LOW) : seq_q.parked;

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |=> $stable(seq_q.mode)); // R7

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> (seq_q.idx <= last_idx)); // R5

endmodule

// File: rtl/i2c_shift_path.sv
module i2c_shift_path #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_tx_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              busy_i,
    input  logic              mode_rx_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              sample_i,
    input  logic              finish_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              ack_stat_o
);

    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] rx_buf;
        logic              ack;
        logic              drv;
    } path_t;

    path_t path_q, path_d;

    always_comb begin
        path_d = path_q;

        if (take_tx_i) begin
            path_d.sr = tx_byte_i;
        end else if (sample_i && (idx_i < ACK_IDX)) begin
            path_d.sr = {path_q.sr[DATA_W-2:0], sda_i};
        end

        if (sample_i && !mode_rx_i && (idx_i == ACK_IDX)) begin
            path_d.ack = sda_i;
        end

        if (finish_i && mode_rx_i) begin
            path_d.rx_buf = {path_q.sr[DATA_W-2:0], sda_i};
        end

        path_d.drv = busy_i && !mode_rx_i && (idx_i < ACK_IDX) && !path_q.sr[DATA_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q <= '0;
        end else begin
            path_q <= path_d;
        end
    end

    assign sda_oe_o   = path_q.drv;
    assign rx_byte_o  = path_q.rx_buf;
    assign ack_stat_o = path_q.ack;

    AST_RX_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && mode_rx_i && $past(busy_i)) |-> !sda_oe_o); // R6

    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !mode_rx_i && (idx_i == ACK_IDX) && ($past(idx_i) == ACK_IDX)) |-> !sda_oe_o); // R3

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
    parameter int DATA_W   = 8,
    parameter int RELOAD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic [DATA_W-1:0]   tx_byte_i,
    input  logic                load_i,
    input  logic                rx_start_i,
    output logic [DATA_W-1:0]   rx_byte_o,
    output logic                ack_stat_o,
    output logic                done_o,
    output logic                busy_o,
    output logic                scl_oe_o,
    output logic                sda_oe_o,
    input  logic                sda_i
);

    localparam int IDX_W = $clog2(DATA_W + 2);

    logic             start_w;
    logic             take_tx_w;
    logic             tick_w;
    logic             busy_w;
    logic             mode_rx_w;
    logic [IDX_W-1:0] idx_w;
    logic             sample_w;
    logic             finish_w;

    i2c_phase_timer #(
        .RELOAD_W (RELOAD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .run_i    (busy_w),
        .reload_i (reload_i),
        .tick_o   (tick_w)
    );

    i2c_bit_sequencer #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .rx_start_i (rx_start_i),
        .tick_i     (tick_w),
        .start_o    (start_w),
        .take_tx_o  (take_tx_w),
        .busy_o     (busy_w),
        .mode_rx_o  (mode_rx_w),
        .idx_o      (idx_w),
        .sample_o   (sample_w),
        .finish_o   (finish_w),
        .done_o     (done_o),
        .scl_oe_o   (scl_oe_o)
    );

    i2c_shift_path #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_tx_i  (take_tx_w),
        .tx_byte_i  (tx_byte_i),
        .busy_i     (busy_w),
        .mode_rx_i  (mode_rx_w),
        .idx_i      (idx_w),
        .sample_i   (sample_w),
        .finish_i   (finish_w),
        .sda_i      (sda_i),
        .sda_oe_o   (sda_oe_o),
        .rx_byte_o  (rx_byte_o),
        .ack_stat_o (ack_stat_o)
    );

    assign busy_o = busy_w;

    AST_SCL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (scl_oe_o && done_o)); // R5

    AST_SDA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o)); // R2

endmodule

// File: tb/i2c_byte_engine_test.sv
module i2c_byte_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reload = 8'd1;
    logic [7:0] tx_byte = 8'h00;
    logic       load = 1'b0;
    logic       rx_start = 1'b0;
    logic [7:0] rx_byte;
    logic       ack_stat;
    logic       done;
    logic       busy;
    logic       scl_oe;
    logic       sda_oe;
    logic       slave_pull = 1'b0;
    logic       scl_line;
    logic       sda_line;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slave_pull);

    i2c_byte_engine uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (reload),
        .tx_byte_i  (tx_byte),
        .load_i     (load),
        .rx_start_i (rx_start),
        .rx_byte_o  (rx_byte),
        .ack_stat_o (ack_stat),
        .done_o     (done),
        .busy_o     (busy),
        .scl_oe_o   (scl_oe),
        .sda_oe_o   (sda_oe),
        .sda_i      (sda_line)
    );

    // slave model
    int         rise_cnt = 0;
    logic       s_rx = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_nack = 1'b0;
    logic [7:0] cap = 8'h00;

    always @(posedge scl_line) begin
        if (!s_rx && rise_cnt < 8) cap = {cap[6:0], sda_line};
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge scl_line) begin
        if (s_rx) slave_pull = (rise_cnt < 8) ? !s_data[7 - rise_cnt] : 1'b0;
        else      slave_pull = (rise_cnt == 8) ? !s_nack : 1'b0;
    end

    // line monitors
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;
    int   hi_run = 0;
    int   last_hi = 0;
    int   stab_err = 0;
    int   ackdrv_err = 0;
    int   rxdrv_err = 0;

    always @(negedge clk) begin
        if (busy && scl_line && prev_scl && (sda_line != prev_sda)) stab_err++;
        if (busy && !s_rx && scl_line && rise_cnt == 9 && sda_oe) ackdrv_err++;
        if (busy && s_rx && sda_oe) rxdrv_err++;
        if (scl_line) hi_run++;
        else begin
            if (hi_run > 0) last_hi = hi_run;
            hi_run = 0;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(input bit is_rx, input logic [7:0] data, input bit nack,
                            input logic [7:0] rel, input bit both, input int inj_at,
                            output int edges);
        rise_cnt   = 0;
        s_rx       = is_rx;
        s_data     = data;
        s_nack     = nack;
        slave_pull = is_rx ? !data[7] : 1'b0;
        cap        = 8'h00;
        stab_err   = 0;
        ackdrv_err = 0;
        rxdrv_err  = 0;
        @(negedge clk);
        reload   = rel;
        tx_byte  = data;
        load     = !is_rx;
        rx_start = is_rx || both;
        @(posedge clk);
        @(negedge clk);
        load     = 1'b0;
        rx_start = 1'b0;
        tx_byte  = 8'h00;
        reload   = 8'd0;
        edges    = 0;
        while (!done && edges < 20000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == inj_at) begin
                tx_byte  = 8'h11;
                load     = 1'b1;
                rx_start = 1'b1;
            end else if (edges == inj_at + 1) begin
                load     = 1'b0;
                rx_start = 1'b0;
                tx_byte  = 8'h00;
            end
        end
        load     = 1'b0;
        rx_start = 1'b0;
    endtask

    // {is_rx, data, nack, reload}
    localparam logic [17:0] VEC [7] = '{
        {1'b0, 8'hA5, 1'b0, 8'd1},
        {1'b0, 8'h3C, 1'b1, 8'd3},
        {1'b1, 8'hC3, 1'b0, 8'd2},
        {1'b0, 8'hFF, 1'b1, 8'd5},
        {1'b1, 8'h5A, 1'b0, 8'd1},
        {1'b0, 8'h01, 1'b0, 8'd4},
        {1'b1, 8'h81, 1'b0, 8'd6}
    };

    logic exp_ack = 1'b0;

    task automatic judge(input bit is_rx, input logic [7:0] data, input bit nack,
                         input logic [7:0] rel, input int edges);
        int exp_edges;
        exp_edges = (is_rx ? 16 : 18) * (int'(rel) + 1);
        if (!is_rx) exp_ack = nack;
        check(edges == exp_edges, "R5 done latency", edges, exp_edges);
        check(done && !busy && scl_oe, "R5 done with busy low and SCL parked",
              {done, busy, scl_oe}, 3'b101);
        check(last_hi == int'(rel) + 1, "R1 SCL high phase length", last_hi, int'(rel) + 1);
        check(ack_stat == exp_ack, "R4 acknowledge status", ack_stat, exp_ack);
        if (is_rx) begin
            check(rx_byte == data, "R6 received byte", rx_byte, data);
            check(rxdrv_err == 0, "R6 master drove SDA in receive", rxdrv_err, 0);
        end else begin
            check(cap == data, "R2 transmitted byte MSB first", cap, data);
            check(stab_err == 0, "R2 SDA changed while SCL high", stab_err, 0);
            check(ackdrv_err == 0, "R3 SDA released on ninth clock", ackdrv_err, 0);
        end
        @(negedge clk);
        check(!done, "R5 done is a single cycle", done, 0);
    endtask

    initial begin
        int edges;
        // R9 reset state
        repeat (3) @(negedge clk);
        check({scl_oe, sda_oe, done, busy, ack_stat} == 5'b0, "R9 reset pins and flags",
              {scl_oe, sda_oe, done, busy, ack_stat}, 0);
        check(rx_byte == 8'h00, "R9 reset receive byte", rx_byte, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!scl_oe && !busy, "R9 idle after reset keeps SCL released", scl_oe, 0);

        for (int i = 0; i < 7; i++) begin
            run_xfer(VEC[i][17], VEC[i][16:9], VEC[i][8], VEC[i][7:0], 1'b0, -5, edges);
            judge(VEC[i][17], VEC[i][16:9], VEC[i][8], VEC[i][7:0], edges);
        end

        // R5 SCL stays parked low while idle
        repeat (20) @(negedge clk);
        check(scl_oe && !busy && !sda_oe, "R5 SCL parked low in idle",
              {scl_oe, busy, sda_oe}, 3'b100);

        // R7 commands during a transmit are ignored
        run_xfer(1'b0, 8'h96, 1'b1, 8'd2, 1'b0, 20, edges);
        judge(1'b0, 8'h96, 1'b1, 8'd2, edges);

        // R7 commands during a receive are ignored
        run_xfer(1'b1, 8'h6E, 1'b0, 8'd3, 1'b0, 30, edges);
        judge(1'b1, 8'h6E, 1'b0, 8'd3, edges);

        // R8 both strobes together: transmit wins
        run_xfer(1'b0, 8'h4B, 1'b0, 8'd1, 1'b1, -5, edges);
        judge(1'b0, 8'h4B, 1'b0, 8'd1, edges);
        check(rx_byte == 8'h6E, "R8 receive request dropped", rx_byte, 8'h6E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule